// File: doc/BRIEF.md
# Program Counter Sequencer with Vectored Interrupts

This block holds the instruction address of a small microcontroller core. It covers an 11-bit space of 2048 instruction words. Each enabled cycle it picks the next address from one of several sources. By default the address advances by one and wraps at the top of memory. A jump or subroutine call strobe loads the target that the instruction carries. A return strobe loads an address popped from an external return stack. An accepted interrupt request forces a fixed vector address.

Five interrupt request lines are served in a fixed priority order, and each has its own vector. The vectors are not evenly spaced. When a call is taken or an interrupt is entered, the block raises a push request. It presents the return address in the same cycle, so the external stack captures it on the same clock edge on which the counter moves. A single global interrupt enable is cleared on interrupt entry. It is set again only by a return-from-interrupt strobe. An advance enable input freezes the whole sequencer while it is low, for example during a memory wait.

Top module: `pc_sequencer`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) sets the counter to 000H and sets the global interrupt enable. The reset is obeyed whatever the other inputs are.
- R2: In an advancing cycle with no interrupt taken and no jump, call or return strobe, the counter becomes PC+1. The step from 7FFH wraps to 000H.
- R3: While step_en is low, the counter holds its value. push_o and irq_ack_o stay 0, and every strobe and request is ignored.
- R4: A jump strobe loads target_i into the counter at the next edge. push_o stays 0.
- R5: A call strobe loads target_i at the next edge. In the same cycle it raises push_o, with push_addr_o equal to PC+1 (wrapping from 7FFH to 000H).
- R6: A return strobe (ret_i) or a return-from-interrupt strobe (reti_i) loads ret_addr_i. Only reti_i sets the global interrupt enable again.
- R7: An accepted request on bit k of irq_req_i loads the vector for that bit at the next edge. The vectors are: bit 0 → 004H, bit 1 → 008H, bit 2 → 00CH, bit 3 → 014H, bit 4 → 020H.
- R8: When several requests are present, the lowest-numbered bit wins. irq_ack_o is one-hot on that bit for the single cycle of acceptance, and it is zero in every other cycle.
- R9: Interrupt entry pushes the current PC, which is the address of the instruction that was pre-empted. An interrupt takes precedence over any jump, call or return strobe in the same cycle.
- R10: Interrupt entry clears the global enable. While the enable is clear, requests are not accepted, and a plain ret_i does not set it again.
- R11: When several strobes arrive in one cycle without an interrupt, call wins over jump, and jump wins over return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step_en | input | 1 | Advance enable; the sequencer freezes while low |
| irq_req_i | input | 5 | Interrupt request lines, bit 0 highest priority |
| jump_i | input | 1 | Jump strobe |
| call_i | input | 1 | Subroutine call strobe |
| target_i | input | 11 | Jump or call target address |
| ret_i | input | 1 | Return-from-subroutine strobe |
| reti_i | input | 1 | Return-from-interrupt strobe |
| ret_addr_i | input | 11 | Address popped from the return stack |
| pc_o | output | 11 | Current program counter |
| push_o | output | 1 | Request to push push_addr_o onto the return stack |
| push_addr_o | output | 11 | Return address to save |
| irq_ack_o | output | 5 | One-hot acknowledge of the served request |

## Verification
A corrupted counter or wrong select shows on pc_o one edge after the offending cycle. This is because every load path has exactly one register between the strobe and the port. A wrong priority or enable state shows at once, combinationally, on irq_ack_o, push_o and push_addr_o in the cycle of the request. A stuck or missing enable bit only shows on the next request after an entry or a return. For that reason the sweep re-requests right after each return. Every target, every request pattern and the wrap point are visited, so a bad bit in the increment or the vector table reaches the port within a few cycles.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

  typedef enum logic [2:0] {
    SEL_HOLD,
    SEL_SEQ,
    SEL_JUMP,
    SEL_CALL,
    SEL_RET,
    SEL_IRQ
  } nsel_e;

  // Vector address for interrupt source idx (0 = highest priority).
  function automatic int unsigned vec_addr(int unsigned idx);
    case (idx)
      0:       return 32'h004;
      1:       return 32'h008;
      2:       return 32'h00C;
      3:       return 32'h014;
      4:       return 32'h020;
      default: return 32'h000;
    endcase
  endfunction

endpackage

// File: rtl/pcseq_irq_arb.sv
module pcseq_irq_arb #(
  parameter int NS = 5,
  localparam int IW = (NS > 1) ? $clog2(NS) : 1
) (
  input  logic [NS-1:0] req,
  input  logic          allow,
  output logic [NS-1:0] grant,
  output logic          any,
  output logic [IW-1:0] idx
);
  logic [NS:0] blocked;
  assign blocked[0] = 1'b0;

  for (genvar i = 0; i < NS; i++) begin : g_pri
    assign blocked[i+1] = blocked[i] | req[i];
    assign grant[i]     = allow & req[i] & ~blocked[i];
  end

  assign any = |grant;

  always_comb begin
    idx = '0;
    for (int i = NS - 1; i >= 0; i--) begin
      if (grant[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/pcseq_next.sv
module pcseq_next #(
  parameter int AW = 11,
  parameter int NS = 5,
  localparam int IW = (NS > 1) ? $clog2(NS) : 1
) (
  input  logic [AW-1:0]      pc_q,
  input  logic               step_en,
  input  logic               irq_take,
  input  logic [IW-1:0]      irq_idx,
  input  logic               jump_i,
  input  logic               call_i,
  input  logic               ret_i,
  input  logic               reti_i,
  input  logic [AW-1:0]      target_i,
  input  logic [AW-1:0]      ret_addr_i,
  output logic [AW-1:0]      pc_d,
  output logic               push,
  output logic [AW-1:0]      push_addr,
  output logic               reti_done,
  output pcseq_pkg::nsel_e   sel
);
  import pcseq_pkg::*;

  function automatic logic [AW-1:0] pc_inc(logic [AW-1:0] a);
    return a + AW'(1);
  endfunction

  function automatic logic [AW-1:0] vec_of(logic [IW-1:0] i);
    return AW'(vec_addr(32'(i)));
  endfunction

  always_comb begin
    if (!step_en)                sel = SEL_HOLD;
    else if (irq_take)           sel = SEL_IRQ;
    else if (call_i)             sel = SEL_CALL;
    else if (jump_i)             sel = SEL_JUMP;
    else if (ret_i || reti_i)    sel = SEL_RET;
    else                         sel = SEL_SEQ;
  end

  always_comb begin
    pc_d      = pc_q;
    push      = 1'b0;
    push_addr = pc_q;
    case (sel)
      SEL_HOLD: pc_d = pc_q;
      SEL_SEQ:  pc_d = pc_inc(pc_q);
      SEL_JUMP: pc_d = target_i;
      SEL_CALL: begin
        pc_d      = target_i;
        push      = 1'b1;
        push_addr = pc_inc(pc_q);
      end
      SEL_RET:  pc_d = ret_addr_i;
      SEL_IRQ: begin
        pc_d      = vec_of(irq_idx);
        push      = 1'b1;
        push_addr = pc_q;
      end
      default:  pc_d = pc_q;
    endcase
  end

  assign reti_done = (sel == SEL_RET) && reti_i;
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer #(
  parameter int AW = 11,
  parameter int NS = 5,
  localparam int IW = (NS > 1) ? $clog2(NS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_en,
  input  logic [NS-1:0] irq_req_i,
  input  logic          jump_i,
  input  logic          call_i,
  input  logic [AW-1:0] target_i,
  input  logic          ret_i,
  input  logic          reti_i,
  input  logic [AW-1:0] ret_addr_i,
  output logic [AW-1:0] pc_o,
  output logic          push_o,
  output logic [AW-1:0] push_addr_o,
  output logic [NS-1:0] irq_ack_o
);
  import pcseq_pkg::*;

  logic [AW-1:0] pc_q, pc_d;
  logic          gie_q;
  logic          irq_take;
  logic [IW-1:0] irq_idx;
  logic          reti_done;
  nsel_e         sel;

  pcseq_irq_arb #(.NS(NS)) u_arb (
    .req   (irq_req_i),
    .allow (gie_q & step_en),
    .grant (irq_ack_o),
    .any   (irq_take),
    .idx   (irq_idx)
  );

  pcseq_next #(.AW(AW), .NS(NS)) u_next (
    .pc_q       (pc_q),
    .step_en    (step_en),
    .irq_take   (irq_take),
    .irq_idx    (irq_idx),
    .jump_i     (jump_i),
    .call_i     (call_i),
    .ret_i      (ret_i),
    .reti_i     (reti_i),
    .target_i   (target_i),
    .ret_addr_i (ret_addr_i),
    .pc_d       (pc_d),
    .push       (push_o),
    .push_addr  (push_addr_o),
    .reti_done  (reti_done),
    .sel        (sel)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q  <= '0;
      gie_q <= 1'b1;
    end else begin
      pc_q <= pc_d;
      if (sel == SEL_IRQ)  gie_q <= 1'b0;
      else if (reti_done)  gie_q <= 1'b1;
    end
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/pcseq_checker.sv
module pcseq_checker #(
  parameter int AW = 11,
  parameter int NS = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          step_en,
  input logic [NS-1:0] irq_req_i,
  input logic          jump_i,
  input logic          call_i,
  input logic          ret_i,
  input logic          reti_i,
  input logic [AW-1:0] pc_o,
  input logic          push_o,
  input logic [AW-1:0] push_addr_o,
  input logic [NS-1:0] irq_ack_o,
  input logic          gie_q
);
  function automatic logic [AW-1:0] oh_vec(logic [NS-1:0] oh);
    logic [AW-1:0] r;
    r = '0;
    for (int i = 0; i < NS; i++) if (oh[i]) r = AW'(pcseq_pkg::vec_addr(i));
    return r;
  endfunction

  assert_ack_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_ack_o));
  assert_ack_subset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack_o & ~irq_req_i) == '0);
  assert_vector_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_ack_o) |=> pc_o == oh_vec($past(irq_ack_o)));
  assert_irq_push_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_ack_o) |-> (push_o && push_addr_o == pc_o));
  assert_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !gie_q |-> irq_ack_o == '0);
  assert_gie_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_ack_o) |=> !gie_q);
  assert_stall_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(pc_o));
  assert_stall_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |-> (!push_o && irq_ack_o == '0));
  assert_call_push_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && call_i && irq_ack_o == '0) |-> (push_o && push_addr_o == pc_o + AW'(1)));
  assert_seq_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !call_i && !jump_i && !ret_i && !reti_i && irq_ack_o == '0)
    |=> pc_o == $past(pc_o) + AW'(1));
endmodule

bind pc_sequencer pcseq_checker #(.AW(AW), .NS(NS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .step_en     (step_en),
  .irq_req_i   (irq_req_i),
  .jump_i      (jump_i),
  .call_i      (call_i),
  .ret_i       (ret_i),
  .reti_i      (reti_i),
  .pc_o        (pc_o),
  .push_o      (push_o),
  .push_addr_o (push_addr_o),
  .irq_ack_o   (irq_ack_o),
  .gie_q       (gie_q)
);

// File: tb/tb_pc_sequencer.sv
module tb_pc_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 11;
  localparam int NS = 5;
  localparam int MASK = (1 << AW) - 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          step_en;
  logic [NS-1:0] irq_req_i;
  logic          jump_i, call_i, ret_i, reti_i;
  logic [AW-1:0] target_i, ret_addr_i;
  logic [AW-1:0] pc_o, push_addr_o;
  logic          push_o;
  logic [NS-1:0] irq_ack_o;

  int n_chk = 0;
  int n_bad = 0;
  int vecs [NS] = '{4, 8, 12, 20, 32};

  always #(CLK_PERIOD/2) clk = ~clk;

  pc_sequencer #(.AW(AW), .NS(NS)) dut (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .irq_req_i(irq_req_i),
    .jump_i(jump_i), .call_i(call_i), .target_i(target_i),
    .ret_i(ret_i), .reti_i(reti_i), .ret_addr_i(ret_addr_i),
    .pc_o(pc_o), .push_o(push_o), .push_addr_o(push_addr_o), .irq_ack_o(irq_ack_o)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_jump(input int t);
    jump_i = 1'b1; target_i = AW'(t);
    cyc();
    jump_i = 1'b0;
  endtask

  function automatic int lowest(input int m);
    for (int i = 0; i < NS; i++) if (m[i]) return i;
    return -1;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; step_en = 1'b1; irq_req_i = '0;
    jump_i = 0; call_i = 0; ret_i = 0; reti_i = 0;
    target_i = '0; ret_addr_i = '0;
    @(negedge clk); cyc(); cyc();
    rst_n = 1'b1;
    chk(pc_o == 0, "R1 reset pc", int'(pc_o), 0);

    // R2 sequential advance
    for (int i = 1; i <= 3; i++) begin
      cyc();
      chk(pc_o == AW'(i), "R2 increment", int'(pc_o), i);
    end

    // R4 every jump target
    for (int t = 0; t <= MASK; t++) begin
      jump_i = 1'b1; target_i = AW'(t);
      #1 chk(!push_o, "R4 no push on jump", int'(push_o), 0);
      cyc();
      chk(pc_o == AW'(t), "R4 jump target", int'(pc_o), t);
    end
    jump_i = 1'b0;

    // R2 wrap
    do_jump(MASK);
    cyc();
    chk(pc_o == 0, "R2 wrap", int'(pc_o), 0);

    // R5 calls
    for (int t = 0; t <= MASK; t += 97) begin
      int p;
      p = int'(pc_o);
      call_i = 1'b1; target_i = AW'(t);
      #1 chk(push_o && int'(push_addr_o) == ((p + 1) & MASK), "R5 call push",
             int'(push_addr_o), (p + 1) & MASK);
      cyc();
      chk(pc_o == AW'(t), "R5 call target", int'(pc_o), t);
    end
    call_i = 1'b0;
    do_jump(MASK);
    call_i = 1'b1; target_i = 11'h123;
    #1 chk(push_o && push_addr_o == 0, "R5 call push wrap", int'(push_addr_o), 0);
    cyc(); call_i = 1'b0;

    // R3 stall ignores everything
    begin
      int held;
      held = int'(pc_o);
      step_en = 1'b0; irq_req_i = '1; jump_i = 1'b1; call_i = 1'b1; target_i = 11'h055;
      for (int k = 0; k < 3; k++) begin
        #1 chk(!push_o && irq_ack_o == 0, "R3 stall quiet", int'(irq_ack_o), 0);
        cyc();
        chk(int'(pc_o) == held, "R3 stall hold", int'(pc_o), held);
      end
      step_en = 1'b1; irq_req_i = '0; jump_i = 1'b0; call_i = 1'b0;
    end

    // R7 R8 R9 R10 R6 over every request pattern
    for (int m = 1; m < (1 << NS); m++) begin
      int base, w, v;
      base = 32'h100 + m;
      w = lowest(m);
      v = vecs[w];
      do_jump(base);
      irq_req_i = NS'(m); call_i = 1'b1; target_i = 11'h7AA;
      #1 chk(int'(irq_ack_o) == (1 << w), "R8 priority ack", int'(irq_ack_o), 1 << w);
      chk(push_o && int'(push_addr_o) == base, "R9 irq push", int'(push_addr_o), base);
      cyc(); call_i = 1'b0;
      chk(int'(pc_o) == v, "R7 vector", int'(pc_o), v);
      #1 chk(irq_ack_o == 0, "R8 R10 masked after entry", int'(irq_ack_o), 0);
      cyc();
      chk(int'(pc_o) == v + 1, "R10 advance while masked", int'(pc_o), v + 1);
      ret_i = 1'b1; ret_addr_i = 11'h300;
      cyc(); ret_i = 1'b0;
      chk(pc_o == 11'h300, "R6 plain return", int'(pc_o), 32'h300);
      #1 chk(irq_ack_o == 0, "R10 plain ret keeps mask", int'(irq_ack_o), 0);
      reti_i = 1'b1; ret_addr_i = AW'(base);
      cyc(); reti_i = 1'b0;
      chk(int'(pc_o) == base, "R6 reti return", int'(pc_o), base);
      #1 chk(int'(irq_ack_o) == (1 << w), "R6 reti re-enables", int'(irq_ack_o), 1 << w);
      irq_req_i = '0;
    end

    // R11 strobe precedence
    do_jump(32'h040);
    call_i = 1'b1; jump_i = 1'b1; ret_i = 1'b1;
    target_i = 11'h2A0; ret_addr_i = 11'h111;
    #1 chk(push_o && push_addr_o == 11'h041, "R11 call wins push", int'(push_addr_o), 32'h41);
    cyc();
    chk(pc_o == 11'h2A0, "R11 call wins", int'(pc_o), 32'h2A0);
    call_i = 1'b0; target_i = 11'h3B0;
    #1 chk(!push_o, "R11 jump no push", int'(push_o), 0);
    cyc();
    chk(pc_o == 11'h3B0, "R11 jump beats ret", int'(pc_o), 32'h3B0);
    jump_i = 1'b0; ret_i = 1'b0;

    // R1 reset with pending requests, mid-run, while masked
    irq_req_i = 5'b00100;
    cyc();
    chk(pc_o == 11'h00C, "R7 entry before reset", int'(pc_o), 32'h00C);
    rst_n = 1'b0; jump_i = 1'b1; target_i = 11'h555;
    cyc();
    chk(pc_o == 0, "R1 reset over strobes", int'(pc_o), 0);
    rst_n = 1'b1; jump_i = 1'b0;
    #1 chk(irq_ack_o == 5'b00100, "R1 reset sets enable", int'(irq_ack_o), 4);
    irq_req_i = '0;
    cyc();

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule